// File: doc/BRIEF.md
# Snooping Three-State Coherence Controller

This block sits beside one private write-back cache on a shared snooping bus and keeps that cache coherent under a write-invalidate policy. Every line of the small direct-mapped cache carries a coherence state: Invalid, Shared (clean and read-only) or Exclusive (sole copy, writable, dirty). The local processor issues reads and writes. Hits finish at once. Misses and upgrades ask an external arbiter for the bus and then place one command on it. A replaced dirty line is written back first.

At the same time the block watches commands that other caches put on the bus. A read miss that targets a line held Exclusive makes the block push the line out and abort the memory access, and the line falls to Shared. A write miss or invalidate that targets a held line removes it, and a dirty line is pushed out first. The block does not change any line on behalf of the processor until it holds the grant. A snoop that lands on the requested line during the wait cancels the pending decision, and the request is evaluated again from the start.

Each cache line stores a single data word. Fill data is taken from the memory-data input in the cycle the command is on the bus.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and bus_req, bus_cmd (00), wb_valid, mem_abort and cpu_ready are all low.
- R2: A read to a Shared or Exclusive line, or a write to an Exclusive line, whose tag matches gives cpu_ready with cpu_hit=1 one cycle after the request is taken. No bus request is made. A read returns the stored word and a write returns the written word on cpu_rdata.
- R3: A read that misses (line Invalid or tag mismatch) places command 01 (read miss) after the grant. The line becomes Shared and holds the word on mem_rdata in that cycle. That word is returned with cpu_hit=0.
- R4: A write that misses places command 10 (write miss) after the grant. The line becomes Exclusive and holds the written word.
- R5: A write whose tag matches a Shared line places command 11 (invalidate) after the grant. The line becomes Exclusive and holds the written word.
- R6: A miss that replaces an Exclusive line drives wb_valid with the victim address and word (mem_abort low) in the cycle after the grant. The miss command follows in the next cycle. Replacing a Shared line makes no write-back.
- R7: A snooped read miss (01) whose tag matches a line held Exclusive raises wb_valid and mem_abort in the same cycle with that line's address and word. The line becomes Shared.
- R8: A snooped write miss (10) or invalidate (11) whose tag matches a held line makes it Invalid. If the line was Exclusive, it is first written back with mem_abort, as in R7. If it was Shared, no write-back takes place.
- R9: A snooped command whose tag does not match the indexed line, or that targets an Invalid line, has no effect on any line or output.
- R10: No line changes and no command is placed before the grant. If a snoop hits the requested line during the wait, the request restarts and is classified again against the new line state.
- R11: When a snoop and an idle processor request target the same line index in one cycle, the snoop is handled first and the request is delayed by one cycle.
- R12: A command other than 00 appears on bus_cmd only while both bus_req and bus_gnt are high.
- R13: cpu_ready is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address (low bits are the index) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completion was served locally |
| cpu_rdata | output | DATA_W | Read data, or the written word for writes |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_cmd | output | 2 | Own command: 00 none, 01 read miss, 10 write miss, 11 invalidate |
| bus_addr | output | ADDR_W | Address of own command |
| mem_rdata | input | DATA_W | Fill word from memory during a read miss |
| wb_valid | output | 1 | Write-back word present |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back word |
| mem_abort | output | 1 | Memory must not answer; this cache supplies the data |
| snp_cmd | input | 2 | Snooped command from another cache, same coding |
| snp_addr | input | ADDR_W | Snooped address |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, 8-bit data and four lines. Addresses that differ only above bit 1 therefore fall on the same line, which makes Exclusive and Shared victims easy to create and makes a snoop that matches the index but not the tag easy to aim. The bench's arbiter can hold back the grant. This keeps a request waiting long enough for a snoop to strike the line in the middle of an upgrade, and the restarted request must then come out as a write miss rather than an invalidate.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_RDMISS = 2'b01,
    CMD_WRMISS = 2'b10,
    CMD_INV    = 2'b11
  } bus_cmd_t;

  typedef enum logic [1:0] {
    ACT_LOCAL,
    ACT_UPGRADE,
    ACT_RDMISS,
    ACT_WRMISS
  } cpu_act_t;

  typedef enum logic [2:0] {
    FSM_IDLE,
    FSM_WAIT,
    FSM_WBACK,
    FSM_ISSUE,
    FSM_RESP
  } fsm_t;

  // Decide what a processor access needs given the indexed line.
  function automatic cpu_act_t classify(logic we, line_st_t st, logic tag_eq);
    if (tag_eq && st != ST_I) begin
      if (!we || st == ST_E) return ACT_LOCAL;
      return ACT_UPGRADE;
    end
    return we ? ACT_WRMISS : ACT_RDMISS;
  endfunction

  function automatic bus_cmd_t act_cmd(cpu_act_t a);
    case (a)
      ACT_UPGRADE: return CMD_INV;
      ACT_RDMISS:  return CMD_RDMISS;
      ACT_WRMISS:  return CMD_WRMISS;
      default:     return CMD_NONE;
    endcase
  endfunction

  // Next state of a line hit by a snooped command.
  function automatic line_st_t snoop_next(line_st_t st, bus_cmd_t c);
    if (c == CMD_RDMISS) return (st == ST_E) ? ST_S : st;
    if (c != CMD_NONE)   return ST_I;
    return st;
  endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cpu_idx,
  output line_st_t          cpu_st,
  output logic [TAG_W-1:0]  cpu_tag,
  output logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_we,
  input  line_st_t          cpu_new_st,
  input  logic [TAG_W-1:0]  cpu_new_tag,
  input  logic [DATA_W-1:0] cpu_new_data,
  input  logic [IDX_W-1:0]  snp_idx,
  output line_st_t          snp_st,
  output logic [TAG_W-1:0]  snp_tag,
  output logic [DATA_W-1:0] snp_data,
  input  logic              snp_we,
  input  line_st_t          snp_new_st
);

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snp_we && snp_idx == IDX_W'(i)) begin
          st_q[i] <= snp_new_st;
        end else if (cpu_we && cpu_idx == IDX_W'(i)) begin
          st_q[i]   <= cpu_new_st;
          tag_q[i]  <= cpu_new_tag;
          data_q[i] <= cpu_new_data;
        end
      end
    end
  end

  assign cpu_st   = st_q[cpu_idx];
  assign cpu_tag  = tag_q[cpu_idx];
  assign cpu_data = data_q[cpu_idx];
  assign snp_st   = st_q[snp_idx];
  assign snp_tag  = tag_q[snp_idx];
  assign snp_data = data_q[snp_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
(
  input  bus_cmd_t snp_cmd,
  input  logic     enable,
  input  line_st_t st,
  input  logic     tag_eq,
  output logic     hit,
  output logic     flush,
  output logic     we,
  output line_st_t new_st
);

  always_comb begin
    hit    = enable && (snp_cmd != CMD_NONE) && (st != ST_I) && tag_eq;
    flush  = hit && (st == ST_E);
    new_st = snoop_next(st, snp_cmd);
    we     = hit && (new_st != st);
  end

endmodule

// File: rtl/msi_cpu_ctrl.sv
module msi_cpu_ctrl
  import msi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  line_st_t          line_st,
  input  logic              tag_eq,
  input  logic [DATA_W-1:0] line_data,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              bus_gnt,
  input  logic              snp_same_idx,
  input  logic              snp_restart,
  output logic              own_bus,
  output logic              bus_req,
  output bus_cmd_t          cmd_o,
  output logic              victim_wb,
  output logic              line_we,
  output line_st_t          line_new_st,
  output logic [DATA_W-1:0] line_new_data,
  output logic              ready,
  output logic              hit,
  output logic [DATA_W-1:0] rdata
);

  fsm_t              state_q;
  cpu_act_t          act_q;
  logic              dirty_q;
  logic              hit_q;
  logic [DATA_W-1:0] rdata_q;
  cpu_act_t          act_now;
  logic              accept;
  logic              fill_rd;

  assign act_now = classify(cpu_we, line_st, tag_eq);
  assign accept  = (state_q == FSM_IDLE) && cpu_req && !snp_same_idx;
  assign fill_rd = (state_q == FSM_ISSUE) && (act_q == ACT_RDMISS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FSM_IDLE;
      act_q   <= ACT_LOCAL;
      dirty_q <= 1'b0;
      hit_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        FSM_IDLE: if (accept) begin
          if (act_now == ACT_LOCAL) begin
            state_q <= FSM_RESP;
            hit_q   <= 1'b1;
            rdata_q <= cpu_we ? cpu_wdata : line_data;
          end else begin
            state_q <= FSM_WAIT;
            act_q   <= act_now;
            dirty_q <= (line_st == ST_E) && (act_now != ACT_UPGRADE);
          end
        end
        FSM_WAIT: begin
          if (snp_restart)  state_q <= FSM_IDLE;
          else if (bus_gnt) state_q <= dirty_q ? FSM_WBACK : FSM_ISSUE;
        end
        FSM_WBACK: state_q <= FSM_ISSUE;
        FSM_ISSUE: begin
          state_q <= FSM_RESP;
          hit_q   <= 1'b0;
          rdata_q <= fill_rd ? mem_rdata : cpu_wdata;
        end
        default: state_q <= FSM_IDLE;
      endcase
    end
  end

  always_comb begin
    own_bus       = (state_q == FSM_WBACK) || (state_q == FSM_ISSUE);
    bus_req       = own_bus || (state_q == FSM_WAIT);
    cmd_o         = (state_q == FSM_ISSUE) ? act_cmd(act_q) : CMD_NONE;
    victim_wb     = (state_q == FSM_WBACK);
    line_we       = (accept && act_now == ACT_LOCAL && cpu_we) || (state_q == FSM_ISSUE);
    line_new_st   = fill_rd ? ST_S : ST_E;
    line_new_data = fill_rd ? mem_rdata : cpu_wdata;
    ready         = (state_q == FSM_RESP);
    hit           = hit_q;
    rdata         = rdata_q;
  end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              mem_abort,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag_in;
  line_st_t          c_st, s_st, c_new_st, s_new_st;
  logic [TAG_W-1:0]  c_tag, s_tag;
  logic [DATA_W-1:0] c_data, s_data, c_new_data;
  logic              c_we, s_we;
  bus_cmd_t          snp_cmd_e, own_cmd;
  logic              own_bus, victim_wb;

  // Named internal events, observed by the checker.
  logic snp_hit, snp_flush, same_idx_evt, restart_evt;

  assign cpu_idx    = cpu_addr[IDX_W-1:0];
  assign cpu_tag    = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx    = snp_addr[IDX_W-1:0];
  assign snp_tag_in = snp_addr[ADDR_W-1:IDX_W];
  assign snp_cmd_e  = bus_cmd_t'(snp_cmd);

  msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_idx(cpu_idx), .cpu_st(c_st), .cpu_tag(c_tag), .cpu_data(c_data),
    .cpu_we(c_we), .cpu_new_st(c_new_st), .cpu_new_tag(cpu_tag), .cpu_new_data(c_new_data),
    .snp_idx(snp_idx), .snp_st(s_st), .snp_tag(s_tag), .snp_data(s_data),
    .snp_we(s_we), .snp_new_st(s_new_st)
  );

  msi_snoop_unit snoop_i (
    .snp_cmd(snp_cmd_e), .enable(!own_bus), .st(s_st), .tag_eq(s_tag == snp_tag_in),
    .hit(snp_hit), .flush(snp_flush), .we(s_we), .new_st(s_new_st)
  );

  assign same_idx_evt = (snp_cmd_e != CMD_NONE) && (snp_idx == cpu_idx);
  assign restart_evt  = snp_hit && (snp_idx == cpu_idx);

  msi_cpu_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .line_st(c_st), .tag_eq(c_tag == cpu_tag), .line_data(c_data),
    .mem_rdata(mem_rdata), .bus_gnt(bus_gnt),
    .snp_same_idx(same_idx_evt), .snp_restart(restart_evt),
    .own_bus(own_bus), .bus_req(bus_req), .cmd_o(own_cmd), .victim_wb(victim_wb),
    .line_we(c_we), .line_new_st(c_new_st), .line_new_data(c_new_data),
    .ready(cpu_ready), .hit(cpu_hit), .rdata(cpu_rdata)
  );

  assign bus_cmd   = own_cmd;
  assign bus_addr  = (own_cmd != CMD_NONE) ? cpu_addr : '0;
  assign mem_abort = snp_flush;
  assign wb_valid  = snp_flush || victim_wb;
  assign wb_addr   = snp_flush ? {s_tag, snp_idx} : (victim_wb ? {c_tag, cpu_idx} : '0);
  assign wb_data   = snp_flush ? s_data : (victim_wb ? c_data : '0);

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       cpu_ready,
  input logic       cpu_hit,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [1:0] bus_cmd,
  input logic       wb_valid,
  input logic       mem_abort,
  input logic       same_idx_evt,
  input logic       restart_evt
);

  a_r12_cmd_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'b00) |-> (bus_req && bus_gnt));

  a_r7_abort_has_wb: assert property (@(posedge clk) disable iff (!rst_n)
    mem_abort |-> wb_valid);

  a_r13_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r2_local_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_hit) |-> $past(!bus_req));

  a_r6_wb_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !mem_abort) |=> (bus_cmd != 2'b00));

  a_r10_restart_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (bus_cmd == 2'b00));

  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (same_idx_evt && cpu_req && !bus_req && !cpu_ready) |=> !cpu_ready);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .wb_valid(wb_valid),
  .mem_abort(mem_abort), .same_idx_evt(same_idx_evt), .restart_evt(restart_evt)
);

// File: tb/msi_snoop_ctrl_tb.sv
module msi_snoop_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       we;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] mdata;
    logic       hit;
    logic [1:0] cmd;
    logic       wb;
    logic [7:0] wba;
    logic [7:0] wbd;
    logic [7:0] rdata;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h10, 8'h00, 8'hA1, 1'b0, 2'd1, 1'b0, 8'h00, 8'h00, 8'hA1},
    '{1'b0, 8'h10, 8'h00, 8'h00, 1'b1, 2'd0, 1'b0, 8'h00, 8'h00, 8'hA1},
    '{1'b1, 8'h10, 8'h5B, 8'h00, 1'b0, 2'd3, 1'b0, 8'h00, 8'h00, 8'h5B},
    '{1'b0, 8'h10, 8'h00, 8'h00, 1'b1, 2'd0, 1'b0, 8'h00, 8'h00, 8'h5B},
    '{1'b1, 8'h10, 8'h66, 8'h00, 1'b1, 2'd0, 1'b0, 8'h00, 8'h00, 8'h66},
    '{1'b0, 8'h20, 8'h00, 8'h77, 1'b0, 2'd1, 1'b1, 8'h10, 8'h66, 8'h77},
    '{1'b1, 8'h31, 8'h42, 8'h00, 1'b0, 2'd2, 1'b0, 8'h00, 8'h00, 8'h42},
    '{1'b1, 8'h41, 8'h43, 8'h00, 1'b0, 2'd2, 1'b1, 8'h31, 8'h42, 8'h43},
    '{1'b1, 8'h20, 8'h88, 8'h00, 1'b0, 2'd3, 1'b0, 8'h00, 8'h00, 8'h88},
    '{1'b0, 8'h12, 8'h00, 8'h99, 1'b0, 2'd1, 1'b0, 8'h00, 8'h00, 8'h99},
    '{1'b1, 8'h52, 8'h9A, 8'h00, 1'b0, 2'd2, 1'b0, 8'h00, 8'h00, 8'h9A}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req = 1'b0, cpu_we = 1'b0;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0, mem_rdata = '0, snp_addr = '0;
  logic [1:0] snp_cmd = '0;
  logic       bus_gnt = 1'b0, gnt_en = 1'b1;
  logic       cpu_ready, cpu_hit, bus_req, wb_valid, mem_abort;
  logic [7:0] cpu_rdata, bus_addr, wb_addr, wb_data;
  logic [1:0] bus_cmd;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Arbiter model: grant one cycle after the request, when enabled.
  always @(posedge clk) bus_gnt <= bus_req && gnt_en;

  msi_snoop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .mem_abort(mem_abort), .snp_cmd(snp_cmd), .snp_addr(snp_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One processor access; an optional snoop rides along in the first cycle.
  task automatic access(input logic we, input logic [7:0] addr, input logic [7:0] wd,
                        input logic [7:0] md, input logic [1:0] scmd, input logic [7:0] saddr,
                        output logic hit, output logic [1:0] cmd, output logic [7:0] cmd_addr,
                        output logic wb, output logic [7:0] wba, output logic [7:0] wbd,
                        output logic [7:0] rd, output int cyc, output int cmd_cyc, output int wb_cyc);
    logic done = 1'b0;
    hit = 1'b0; cmd = 2'd0; cmd_addr = '0; wb = 1'b0; wba = '0; wbd = '0; rd = '0;
    cyc = 0; cmd_cyc = 0; wb_cyc = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; mem_rdata = md;
    snp_cmd = scmd; snp_addr = saddr;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      snp_cmd = 2'd0;
      if (bus_cmd != 2'd0) begin cmd = bus_cmd; cmd_addr = bus_addr; cmd_cyc = cyc; end
      if (wb_valid) begin wb = 1'b1; wba = wb_addr; wbd = wb_data; wb_cyc = cyc; end
      if (cpu_ready) begin done = 1'b1; hit = cpu_hit; rd = cpu_rdata; end
    end
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a,
                       output logic wb, output logic ab, output logic [7:0] wba, output logic [7:0] wbd);
    @(negedge clk);
    snp_cmd = c; snp_addr = a;
    #1;
    wb = wb_valid; ab = mem_abort; wba = wb_addr; wbd = wb_data;
    @(negedge clk);
    snp_cmd = 2'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic h, w, ab; logic [1:0] c; logic [7:0] ca, wa, wd, rd;
    int cy, ccy, wcy;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 bus_cmd", bus_cmd, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 mem_abort", mem_abort, 0);
    chk("R1 cpu_ready", cpu_ready, 0);

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].mdata, 2'd0, 8'h00,
             h, c, ca, w, wa, wd, rd, cy, ccy, wcy);
      chk(VECS[i].hit ? "R2 hit" : "R3/R4/R5 miss flag", h, VECS[i].hit);
      chk(VECS[i].cmd == 2'd1 ? "R3 cmd" : VECS[i].cmd == 2'd2 ? "R4 cmd" :
          VECS[i].cmd == 2'd3 ? "R5 cmd" : "R2 no cmd", c, VECS[i].cmd);
      chk("R2/R3/R4/R5 rdata", rd, VECS[i].rdata);
      chk("R6 writeback seen", w, VECS[i].wb);
      if (VECS[i].hit) chk("R2 latency", cy, 1);
      if (VECS[i].cmd != 2'd0) chk("R3 cmd addr", ca, VECS[i].addr);
      if (VECS[i].wb) begin
        chk("R6 wb addr", wa, VECS[i].wba);
        chk("R6 wb data", wd, VECS[i].wbd);
        chk("R6 cmd after wb", ccy, wcy + 1);
      end
    end

    // R7: snooped read miss on an Exclusive line.
    snoop(2'd1, 8'h20, w, ab, wa, wd);
    chk("R7 wb", w, 1); chk("R7 abort", ab, 1);
    chk("R7 wb addr", wa, 8'h20); chk("R7 wb data", wd, 8'h88);
    access(1'b0, 8'h20, 8'h00, 8'h00, 2'd0, 8'h00, h, c, ca, w, wa, wd, rd, cy, ccy, wcy);
    chk("R7 still readable", h, 1); chk("R7 data kept", rd, 8'h88);
    access(1'b1, 8'h20, 8'h89, 8'h00, 2'd0, 8'h00, h, c, ca, w, wa, wd, rd, cy, ccy, wcy);
    chk("R7 now Shared (upgrade)", c, 2'd3);

    // R8: write miss on Exclusive, invalidate on Shared.
    snoop(2'd2, 8'h41, w, ab, wa, wd);
    chk("R8 E wb", w, 1); chk("R8 E abort", ab, 1); chk("R8 E wb data", wd, 8'h43);
    access(1'b0, 8'h41, 8'h00, 8'h55, 2'd0, 8'h00, h, c, ca, w, wa, wd, rd, cy, ccy, wcy);
    chk("R8 E now Invalid", c, 2'd1); chk("R8 no victim wb", w, 0);
    snoop(2'd3, 8'h41, w, ab, wa, wd);
    chk("R8 S no wb", w, 0); chk("R8 S no abort", ab, 0);
    access(1'b0, 8'h41, 8'h00, 8'h56, 2'd0, 8'h00, h, c, ca, w, wa, wd, rd, cy, ccy, wcy);
    chk("R8 S now Invalid", c, 2'd1); chk("R8 refill", rd, 8'h56);

    // R9: snoops that miss on tag or hit an Invalid line.
    snoop(2'd2, 8'h60, w, ab, wa, wd);
    chk("R9 tag mismatch no wb", w, 0); chk("R9 tag mismatch no abort", ab, 0);
    snoop(2'd1, 8'h13, w, ab, wa, wd);
    chk("R9 invalid line no wb", w, 0);
    access(1'b0, 8'h20, 8'h00, 8'h00, 2'd0, 8'h00, h, c, ca, w, wa, wd, rd, cy, ccy, wcy);
    chk("R9 line untouched hit", h, 1); chk("R9 line untouched data", rd, 8'h89);

    // R11: snoop to the same index in the request cycle delays it by one.
    access(1'b0, 8'h20, 8'h00, 8'h00, 2'd1, 8'h60, h, c, ca, w, wa, wd, rd, cy, ccy, wcy);
    chk("R11 stall latency", cy, 2); chk("R11 hit", h, 1); chk("R11 data", rd, 8'h89);

    // R10: restart when a snoop kills the line during the wait.
    access(1'b0, 8'h13, 8'h00, 8'h31, 2'd0, 8'h00, h, c, ca, w, wa, wd, rd, cy, ccy, wcy);
    chk("R10 setup Shared fill", rd, 8'h31);
    gnt_en = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h13; cpu_wdata = 8'h44;
    repeat (3) @(negedge clk);
    chk("R10 waiting bus_req", bus_req, 1);
    chk("R10 no cmd before grant", bus_cmd, 0);
    chk("R10 no ready before grant", cpu_ready, 0);
    snp_cmd = 2'd2; snp_addr = 8'h13;
    #1;
    chk("R10 snoop on Shared no wb", wb_valid, 0);
    @(negedge clk);
    snp_cmd = 2'd0; gnt_en = 1'b1;
    c = 2'd0; h = 1'b1; rd = '0;
    for (int k = 0; k < 50 && !cpu_ready; k++) begin
      @(negedge clk);
      if (bus_cmd != 2'd0) c = bus_cmd;
      if (cpu_ready) begin h = cpu_hit; rd = cpu_rdata; end
    end
    cpu_req = 1'b0;
    chk("R10 restarted as write miss", c, 2'd2);
    chk("R10 miss flag", h, 0);
    chk("R10 written data", rd, 8'h44);
    @(negedge clk);
    chk("R13 ready dropped", cpu_ready, 0);
    access(1'b0, 8'h13, 8'h00, 8'h00, 2'd0, 8'h00, h, c, ca, w, wa, wd, rd, cy, ccy, wcy);
    chk("R10 line Exclusive hit", h, 1); chk("R10 line data", rd, 8'h44);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule